// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block is a general-purpose 16-bit counter with an 8-bit prescaler in front of it. A mode field picks what makes the counter advance and what happens on its events. The choices are a free-running time base, counting edges on an event pin, accumulating time while the event pin is held active, capturing the count on a capture-pin edge (with or without clearing the counter), dual compare, and a self-running PWM generator. Together, the prescaler and the counter give a time base of up to 24 bits.

Software reaches the block through a simple word-wide register port. Writes are synchronous and reads are combinational. The registers are: configuration at address 0, counter at 1, compare A at 2, compare B at 3, capture at 4 (read-only), event flags at 5 (write 1 to clear) and interrupt enables at 6. Both pins pass through a two-stage synchronizer before any edge or level is used. A halt input freezes all counting and edge recognition.

Top module: `flex_timer`

## Requirements
- R1: After reset, the counter, capture, compare, flag and enable registers read 0, and `pwmOut` and `irq` are low.
- R2: Config bits [2:0] select the mode (0 free, 1 event, 2 accumulate, 3 capture, 4 capture-and-clear, 5 compare, 6 PWM). Bit 4 is run and bits [15:8] are the prescale value D. In modes 0, 3, 4, 5 and 6 the counter steps once every D+1 clocks, counting from the clock edge that wrote the config.
- R3: In mode 1 the counter adds 1 per active edge of `evtPin`. Config bit 3 selects the polarity: 0 means a rising edge is active, 1 means a falling edge is active.
- R4: In mode 2 the counter steps on the prescaled tick only while `evtPin` is at its active level: high when bit 3 is 0, low when it is 1.
- R5: In modes 3 and 4, an active `capPin` edge (same polarity bit) copies the counter into the capture register and sets flag bit 1. The copy happens on the third clock edge after the pin changes and takes the count held just before that edge.
- R6: In mode 4, the capturing edge also clears the counter to 0 in place of a step.
- R7: A step that lands on compare A sets flag bit 2, and one that lands on compare B sets flag bit 3.
- R8: A step from 0xFFFF wraps the counter to 0 and sets flag bit 0.
- R9: In mode 6 a step from count == compare B clears the counter and drives `pwmOut` high. A step landing on compare A drives it low. The period is therefore B+1 steps, with a high time of A steps.
- R10: Writing 1 to a bit of the flag register clears that bit, while a bit being set in the same cycle still sets. `irq` is high whenever a flag and its enable bit (address 6) are both 1.
- R11: While `haltIn` is high, the counter does not change.
- R12: A write to the counter register loads it and overrides a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 16 | Read data for rdAddr |
| evtPin | input | 1 | External event / gate input |
| capPin | input | 1 | Capture / counter-clear input |
| haltIn | input | 1 | Freezes the timer while high |
| pwmOut | output | 1 | PWM waveform |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a capture edge whose latched value is known exactly. The pin's edge crosses a synchronizer and an edge detector while the counter keeps stepping. The bench first clears the counter with run off and then starts it with a single write. Because the count is then known at every clock, the pin can be raised at a chosen clock and the expected capture worked out from the three-edge latency. A similar timed sequence makes a compare-B match and a write-1-to-clear of compare-A's flag fall on the same clock edge.

// File: rtl/flex_timer_pkg.sv
package flex_timer_pkg;
  typedef enum logic [2:0] {
    MODE_FREE   = 3'd0,
    MODE_EVENT  = 3'd1,
    MODE_ACCUM  = 3'd2,
    MODE_CAPT   = 3'd3,
    MODE_CAPRST = 3'd4,
    MODE_CMP    = 3'd5,
    MODE_PWM    = 3'd6,
    MODE_OFF    = 3'd7
  } modeT;

  typedef struct packed {
    logic step;
    logic capEdge;
    logic capClear;
    logic pwmMode;
  } strobeT;

  localparam int FLAG_N   = 4;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_CAP = 1;
  localparam int FLAG_CA  = 2;
  localparam int FLAG_CB  = 3;

  localparam logic [2:0] ADDR_CFG  = 3'd0;
  localparam logic [2:0] ADDR_CNT  = 3'd1;
  localparam logic [2:0] ADDR_CMPA = 3'd2;
  localparam logic [2:0] ADDR_CMPB = 3'd3;
  localparam logic [2:0] ADDR_CAP  = 3'd4;
  localparam logic [2:0] ADDR_FLAG = 3'd5;
  localparam logic [2:0] ADDR_EN   = 3'd6;
endpackage

// File: rtl/flex_timer_ctrl.sv
module flex_timer_ctrl
  import flex_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CNT_W-1:0] cfgData,
  input  logic             evtPin,
  input  logic             capPin,
  input  logic             haltIn,
  output logic [CNT_W-1:0] cfgOut,
  output strobeT           stb
);
  localparam int PIN_N   = 2;
  localparam int DIV_LSB = 8;

  logic [CNT_W-1:0] cfgReg;
  logic [PRE_W-1:0] preCnt;
  logic [PIN_N-1:0] pinRaw, pinSync, pinPol, pinPrev, pinEdge;
  modeT             mode;
  logic             polSel, runBit, active, tick;
  logic [PRE_W-1:0] divVal;

  assign mode   = modeT'(cfgReg[2:0]);
  assign polSel = cfgReg[3];
  assign runBit = cfgReg[4];
  assign divVal = cfgReg[DIV_LSB +: PRE_W];
  assign cfgOut = cfgReg;
  assign pinRaw = {capPin, evtPin};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) cfgReg <= '0;
    else if (cfgWr) cfgReg <= cfgData;

  // per-pin synchronizer chain
  for (genvar g = 0; g < PIN_N; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] shReg;
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) shReg <= '0;
      else       shReg <= {shReg[SYNC_STAGES-2:0], pinRaw[g]};
    assign pinSync[g] = shReg[SYNC_STAGES-1];
  end

  assign pinPol  = pinSync ^ {PIN_N{polSel}};
  assign pinEdge = pinPol & ~pinPrev;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinPol;

  assign active = runBit && !haltIn;
  assign tick   = active && (preCnt == divVal);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)       preCnt <= '0;
    else if (cfgWr)  preCnt <= '0;
    else if (active) preCnt <= tick ? '0 : preCnt + 1'b1;

  always_comb begin
    stb          = '0;
    stb.pwmMode  = (mode == MODE_PWM);
    stb.capClear = (mode == MODE_CAPRST);
    stb.capEdge  = active && pinEdge[1] &&
                   (mode == MODE_CAPT || mode == MODE_CAPRST);
    unique case (mode)
      MODE_EVENT: stb.step = active && pinEdge[0];
      MODE_ACCUM: stb.step = tick && pinPol[0];
      MODE_OFF:   stb.step = 1'b0;
      default:    stb.step = tick;
    endcase
  end

  // R11
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltIn |-> (!stb.step && !stb.capEdge));

  // R2
  stopped_no_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |-> !stb.step);
endmodule

// File: rtl/flex_timer_dp.sv
module flex_timer_dp
  import flex_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  strobeT            stb,
  output logic [CNT_W-1:0]  countOut,
  output logic [CNT_W-1:0]  cmpAOut,
  output logic [CNT_W-1:0]  cmpBOut,
  output logic [CNT_W-1:0]  capOut,
  output logic [FLAG_N-1:0] flagOut,
  output logic [FLAG_N-1:0] enOut,
  output logic              pwmOut,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  count, cmpA, cmpB, capReg, nextCount;
  logic [FLAG_N-1:0] flagReg, enReg, setVec, clrVec;
  logic cntWr, advance, pwmWrap, capHit;

  assign cntWr     = wrEn && (wrAddr == ADDR_CNT);
  assign capHit    = stb.capEdge && stb.capClear;
  assign advance   = stb.step && !cntWr && !capHit;
  assign pwmWrap   = stb.pwmMode && (count == cmpB);
  assign nextCount = pwmWrap ? '0 : count + 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)        count <= '0;
    else if (cntWr)   count <= wrData;
    else if (capHit)  count <= '0;
    else if (advance) count <= nextCount;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      cmpA  <= '0;
      cmpB  <= '0;
      enReg <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_CMPA) cmpA  <= wrData;
      if (wrAddr == ADDR_CMPB) cmpB  <= wrData;
      if (wrAddr == ADDR_EN)   enReg <= wrData[FLAG_N-1:0];
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              capReg <= '0;
    else if (stb.capEdge)   capReg <= count;

  always_comb begin
    setVec           = '0;
    setVec[FLAG_OVF] = advance && !pwmWrap && (count == CNT_MAX);
    setVec[FLAG_CAP] = stb.capEdge;
    setVec[FLAG_CA]  = advance && (nextCount == cmpA);
    setVec[FLAG_CB]  = advance && (stb.pwmMode ? pwmWrap : (nextCount == cmpB));
    clrVec           = (wrEn && wrAddr == ADDR_FLAG) ? wrData[FLAG_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) flagReg <= '0;
    else       flagReg <= (flagReg & ~clrVec) | setVec;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             pwmOut <= 1'b0;
    else if (!stb.pwmMode) pwmOut <= 1'b0;
    else if (advance) begin
      if (pwmWrap)                  pwmOut <= 1'b1;
      else if (nextCount == cmpA)   pwmOut <= 1'b0;
    end

  assign irq      = |(flagReg & enReg);
  assign countOut = count;
  assign cmpAOut  = cmpA;
  assign cmpBOut  = cmpB;
  assign capOut   = capReg;
  assign flagOut  = flagReg;
  assign enOut    = enReg;

  // R8
  ovf_from_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagReg[FLAG_OVF]) |-> ($past(count) == CNT_MAX && count == '0));

  // R5
  cap_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capReg != $past(capReg)) |-> $past(stb.capEdge));

  // R7
  cmpa_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flagReg[FLAG_CA]) && !$past(wrEn && wrAddr == ADDR_CMPA)) |-> (count == cmpA));

  // R9
  pwm_rise_on_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> (count == '0 && $past(stb.pwmMode)));

  // R12
  cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (count == $past(wrData)));
endmodule

// File: rtl/flex_timer.sv
module flex_timer
  import flex_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic             evtPin,
  input  logic             capPin,
  input  logic             haltIn,
  output logic             pwmOut,
  output logic             irq
);
  localparam int PAD_W = CNT_W - FLAG_N;

  strobeT            stb;
  logic [CNT_W-1:0]  cfgVal, countVal, cmpAVal, cmpBVal, capVal;
  logic [FLAG_N-1:0] flagVal, enVal;

  flex_timer_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWr(wrEn && wrAddr == ADDR_CFG), .cfgData(wrData),
    .evtPin(evtPin), .capPin(capPin), .haltIn(haltIn),
    .cfgOut(cfgVal), .stb(stb)
  );

  flex_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .stb(stb),
    .countOut(countVal), .cmpAOut(cmpAVal), .cmpBOut(cmpBVal),
    .capOut(capVal), .flagOut(flagVal), .enOut(enVal),
    .pwmOut(pwmOut), .irq(irq)
  );

  always_comb
    unique case (rdAddr)
      ADDR_CFG:  rdData = cfgVal;
      ADDR_CNT:  rdData = countVal;
      ADDR_CMPA: rdData = cmpAVal;
      ADDR_CMPB: rdData = cmpBVal;
      ADDR_CAP:  rdData = capVal;
      ADDR_FLAG: rdData = {{PAD_W{1'b0}}, flagVal};
      ADDR_EN:   rdData = {{PAD_W{1'b0}}, enVal};
      default:   rdData = '0;
    endcase
endmodule

// File: tb/flex_timer_bench.sv
module flex_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        evtPin = 1'b0, capPin = 1'b0, haltIn = 1'b0;
  logic        pwmOut, irq;
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flex_timer u_flex_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtPin(evtPin), .capPin(capPin),
    .haltIn(haltIn), .pwmOut(pwmOut), .irq(irq)
  );

  // mode, pol, div, evt level, cycles, expected count
  localparam logic [44:0] VECS [8] = '{
    {3'd0, 1'b0, 8'd0,   1'b0, 16'd10,   16'd10},
    {3'd0, 1'b0, 8'd3,   1'b0, 16'd20,   16'd5},
    {3'd0, 1'b0, 8'd255, 1'b0, 16'd1024, 16'd4},
    {3'd2, 1'b0, 8'd1,   1'b1, 16'd12,   16'd6},
    {3'd2, 1'b0, 8'd1,   1'b0, 16'd12,   16'd0},
    {3'd2, 1'b1, 8'd0,   1'b0, 16'd9,    16'd9},
    {3'd5, 1'b0, 8'd4,   1'b0, 16'd25,   16'd5},
    {3'd3, 1'b0, 8'd2,   1'b0, 16'd9,    16'd3}
  };
  localparam logic [9:0] PWM_EXP = 10'b1000110000;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic setup(input logic [2:0] mode, input logic pol, input logic [7:0] div);
    wr(3'd0, {div, 3'b000, 1'b0, pol, mode});
    repeat (4) @(negedge clk);
    wr(3'd1, 16'h0000);
    wr(3'd0, {div, 3'b000, 1'b1, pol, mode});
  endtask

  task automatic pulse(input bit isCap);
    @(negedge clk);
    if (isCap) capPin = 1'b1; else evtPin = 1'b1;
    repeat (2) @(negedge clk);
    if (isCap) capPin = 1'b0; else evtPin = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 1; a <= 6; a++) begin
      rd(a[2:0], v);
      check("R1 reset register", v, 16'h0000);
    end
    check("R1 reset pwm/irq", {14'b0, pwmOut, irq}, 16'h0000);

    // R2 / R4 table of modes
    for (int i = 0; i < 8; i++) begin
      logic [44:0] t;
      t = VECS[i];
      evtPin = t[32];
      setup(t[44:42], t[41], t[40:33]);
      repeat (int'(t[31:16])) @(negedge clk);
      rd(3'd1, v);
      check(t[44:42] == 3'd2 ? "R4 accumulate count" : "R2 prescaled count", v, t[15:0]);
    end
    evtPin = 1'b0;

    // R3 event counting, both polarities
    setup(3'd1, 1'b0, 8'd0);
    for (int k = 0; k < 5; k++) pulse(1'b0);
    repeat (4) @(negedge clk);
    rd(3'd1, v);
    check("R3 rising edges", v, 16'd5);
    setup(3'd1, 1'b1, 8'd0);
    for (int k = 0; k < 3; k++) pulse(1'b0);
    repeat (4) @(negedge clk);
    rd(3'd1, v);
    check("R3 falling edges", v, 16'd3);

    // R5 capture
    wr(3'd5, 16'h000F);
    setup(3'd3, 1'b0, 8'd0);
    repeat (6) @(negedge clk);
    capPin = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd4, v);
    check("R5 captured value", v, 16'd8);
    rd(3'd1, v);
    check("R5 counter keeps running", v, 16'd9);
    rd(3'd5, v);
    check("R5 capture flag", v & 16'h0002, 16'h0002);
    capPin = 1'b0;

    // R6 capture and clear
    setup(3'd4, 1'b0, 8'd0);
    repeat (6) @(negedge clk);
    capPin = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd1, v);
    check("R6 counter cleared", v, 16'd0);
    rd(3'd4, v);
    check("R6 captured value", v, 16'd8);
    repeat (2) @(negedge clk);
    rd(3'd1, v);
    check("R6 counts again", v, 16'd2);
    capPin = 1'b0;

    // R7 / R10 compare flags and interrupt
    wr(3'd2, 16'd5);
    wr(3'd3, 16'd9);
    wr(3'd0, 16'h0005);
    wr(3'd5, 16'h000F);
    setup(3'd5, 1'b0, 8'd0);
    repeat (4) @(negedge clk);
    rd(3'd5, v);
    check("R7 no match before A", v, 16'h0000);
    @(negedge clk);
    rd(3'd5, v);
    check("R7 match A flag", v, 16'h0004);
    check("R10 irq masked", {15'b0, irq}, 16'h0000);
    wr(3'd6, 16'h0004);
    check("R10 irq enabled", {15'b0, irq}, 16'h0001);
    wr(3'd5, 16'h0004);
    rd(3'd5, v);
    check("R10 clear A while B sets", v, 16'h0008);
    check("R10 irq after clear", {15'b0, irq}, 16'h0000);

    // R8 overflow
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'h000F);
    wr(3'd1, 16'hFFFE);
    wr(3'd0, 16'h0010);
    @(negedge clk);
    rd(3'd1, v);
    check("R8 at max", v, 16'hFFFF);
    rd(3'd5, v);
    check("R8 no flag yet", v & 16'h0001, 16'h0000);
    @(negedge clk);
    rd(3'd1, v);
    check("R8 wrapped", v, 16'h0000);
    rd(3'd5, v);
    check("R8 overflow flag", v & 16'h0001, 16'h0001);

    // R9 PWM
    wr(3'd2, 16'd2);
    wr(3'd3, 16'd4);
    setup(3'd6, 1'b0, 8'd0);
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      check("R9 pwm level", {15'b0, pwmOut}, {15'b0, PWM_EXP[n]});
    end

    // R11 halt
    setup(3'd0, 1'b0, 8'd0);
    repeat (3) @(negedge clk);
    haltIn = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd1, v);
    check("R11 frozen while halted", v, 16'd3);
    haltIn = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd1, v);
    check("R11 resumes", v, 16'd5);

    // R12 counter write while running
    wr(3'd1, 16'd100);
    rd(3'd1, v);
    check("R12 write wins", v, 16'd100);
    @(negedge clk);
    rd(3'd1, v);
    check("R12 counts from written", v, 16'd101);

    finish_run();
  end
endmodule